// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Sequencer

This block is the digital control core of a four-slot simultaneous-sampling analog-to-digital converter. A host sets the operating mode by writing a 4-bit word over a shared parallel bus, qualified by active-low chip select and write strobes. A rising edge on the convert-start input freezes all four track/holds together. The block then walks an external successive-approximation core through one to four conversions, in ascending channel order, and stores each 12-bit two's-complement result in a four-entry result store.

When the last conversion of a sequence ends, the track/holds are released and the active-low interrupt falls. The host then pulls the results out with active-low read strobes. Reads go through a sequential pointer, not an address: the first read always returns channel 1, and the pointer wraps after four reads. A control word with its top bit set puts the converter into power-down. A later word with that bit clear wakes it, but conversions are accepted only after a settling interval. All strobes are asynchronous to the system clock, so each one passes through a two-flop synchronizer before its edges are detected.

Top module: `ssq_top`

## Requirements
- R1: After reset, int_n is 1 and bus_oe, th_hold, pwr_dn and sar_start are 0. The mode is bank A (sar_bank 0) with one channel per sequence.
- R2: A control word is taken from ctrl_in on the rising edge of wr_n while cs_n is low. Bits [1:0] hold the channel count minus one. Bit 2 selects the bank (0 = A, 1 = B), and sar_bank reports it during the sequence. The mode stays in force until the next accepted write.
- R3: If cs_n rises while wr_n is still low, the word is taken at that cs_n edge. Bus changes and a wr_n rise that come after it have no effect.
- R4: While cs_n is high, wr_n and rd_n pulses do not change the mode or the read pointer, and bus_oe stays 0.
- R5: A rising edge of conv_start raises th_hold. It also issues one sar_start pulse per programmed channel, with sar_chan counting 0, 1, 2, 3 in that order.
- R6: th_hold stays high for exactly N×CONV_CLKS clocks for N channels. int_n falls in the same cycle that th_hold falls.
- R7: A conv_start edge that arrives while a sequence is running neither restarts nor extends the sequence.
- R8: bus_oe is 1 only while cs_n and rd_n are both low. data_out carries the value that sar_data held at the sar_done of the pointed channel. A read falling edge with cs_n low returns int_n to 1.
- R9: Each completed read (rd_n rising with cs_n low) advances the pointer. The pointer returns to channel 1 after four reads, whatever the channel count. Any conv_start edge also returns it to channel 1.
- R10: A word with bit 3 set raises pwr_dn, and conv_start is then ignored. A word with bit 3 clear wakes the block in the mode given by bits [2:0]. conv_start is ignored for PWRUP_CLKS clocks after the wake write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| conv_start | input | 1 | Rising edge starts sampling |
| ctrl_in | input | 4 | Control word from the shared bus |
| data_out | output | DATA_W | Result at the read pointer |
| bus_oe | output | 1 | Drive enable for the shared bus |
| int_n | output | 1 | Falls at the end of a sequence |
| th_hold | output | 1 | Track/holds frozen while high |
| pwr_dn | output | 1 | Power-down in force |
| sar_start | output | 1 | One-cycle start to the SAR core |
| sar_chan | output | 2 | Channel being converted |
| sar_bank | output | 1 | Input bank for the sequence |
| sar_done | input | 1 | SAR core result valid |
| sar_data | input | DATA_W | SAR core result |

## Verification
The bench goes after the read pointer. It reads past the channel count to show the wrap at four, and it reads after a fresh conv_start to show the pointer reset. A pointer that wrapped at the channel count would return channel 1 data on the third read of a two-channel sequence. The bench also fires conv_start in the middle of a sequence, where a design that restarts would stretch th_hold and issue extra starts. It lifts chip select before write in one test, where a design that waits for wr_n would latch the later garbage. Finally it starts a conversion during the wake-up settling time, where a design that skips the settling delay would convert early.

// File: rtl/ssq_pkg.sv
// Shared types for the sequencer: control word layout and FSM states.
// Assumes exactly four track/hold slots, fixed by the control word format.
package ssq_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int CTRL_W = 4;

    typedef struct packed {
        logic       pd;      // bit 3: power-down request
        logic       bank;    // bit 2: input bank select
        logic [1:0] cnt_m1;  // bits 1:0: channels minus one
    } mode_t;

    localparam mode_t MODE_RESET = '{pd: 1'b0, bank: 1'b0, cnt_m1: 2'd0};

    typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;
endpackage

// File: rtl/ssq_sync.sv
// Two-flop synchronizer bank with one extra history flop.
// Outputs the synchronized level and the level one clock earlier, so that
// edge detection can be done by the consumer. Idle level of all inputs is 1.
module ssq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] s1, s2, s3;

    // Shift asynchronous inputs through the metastability and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '1;
            s2 <= '1;
            s3 <= '1;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign prev = s3;
endmodule

// File: rtl/ssq_mode_reg.sv
// Control-word capture, power-down state and wake-up settling timer.
// Assumes the bus nibble is stable while the synchronized write strobe is low.
module ssq_mode_reg
    import ssq_pkg::*;
#(
    parameter int PWRUP_CLKS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_prev,
    input  logic              wr_lvl,
    input  logic              wr_prev,
    input  logic [CTRL_W-1:0] bus_nib,
    output mode_t             mode,
    output logic              ready
);
    localparam int SET_W = $clog2(PWRUP_CLKS + 1);

    logic [CTRL_W-1:0] hold_word;
    logic [SET_W-1:0]  settle;
    logic              cap;

    // The earlier of the WR and CS rising edges closes a write cycle.
    assign cap = (wr_lvl && !wr_prev && !cs_prev) ||
                 (cs_lvl && !cs_prev && !wr_prev);

    // Track the bus while both strobes are low; the last value is the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_word <= '0;
        else if (!wr_lvl && !cs_lvl)
            hold_word <= bus_nib;
    end

    // Apply a captured word: power-down keeps the old mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_RESET;
        else if (cap) begin
            if (hold_word[3])
                mode.pd <= 1'b1;
            else
                mode <= '{pd: 1'b0, bank: hold_word[2], cnt_m1: hold_word[1:0]};
        end
    end

    // Load the settling timer on wake, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle <= '0;
        else if (cap && !hold_word[3] && mode.pd)
            settle <= SET_W'(PWRUP_CLKS);
        else if (settle != '0)
            settle <= settle - 1'b1;
    end

    assign ready = !mode.pd && (settle == '0);

    // R10: leaving power-down never makes the converter ready at once.
    a_r10_wake_settles: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode.pd) |-> !ready);
endmodule

// File: rtl/ssq_sequencer.sv
// Conversion sequencer: freezes the track/holds, runs one SAR slot of
// CONV_CLKS clocks per channel in ascending order, owns the interrupt flag.
// Assumes the SAR core pulses sar_done once inside each slot.
module ssq_sequencer
    import ssq_pkg::*;
#(
    parameter int CONV_CLKS = 32,
    parameter int DATA_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              ready,
    input  logic [1:0]        cnt_m1,
    input  logic              bank,
    input  logic              int_clr,
    input  logic              sar_done,
    input  logic [DATA_W-1:0] sar_data,
    output logic              sar_start,
    output logic [CH_W-1:0]   sar_chan,
    output logic              sar_bank,
    output logic              th_hold,
    output logic              int_n,
    output logic              mem_we,
    output logic [CH_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int CNT_W = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CLKS - 1);

    seq_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0] slot;
    logic [CH_W-1:0] last;
    logic            bank_q;

    // Step through slots, issue SAR starts and end the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            slot      <= '0;
            last      <= '0;
            bank_q    <= 1'b0;
            sar_start <= 1'b0;
            th_hold   <= 1'b0;
            int_n     <= 1'b1;
        end else begin
            sar_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req && ready) begin
                        state     <= ST_CONV;
                        cnt       <= '0;
                        slot      <= '0;
                        last      <= cnt_m1;
                        bank_q    <= bank;
                        sar_start <= 1'b1;
                        th_hold   <= 1'b1;
                        int_n     <= 1'b1;
                    end else if (int_clr) begin
                        int_n <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        if (slot == last) begin
                            state   <= ST_IDLE;
                            th_hold <= 1'b0;
                            int_n   <= 1'b0;
                        end else begin
                            slot      <= slot + 1'b1;
                            sar_start <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sar_chan  = slot;
    assign sar_bank  = bank_q;
    assign mem_we    = (state == ST_CONV) && sar_done;
    assign mem_addr  = slot;
    assign mem_wdata = sar_data;

    // R5: every SAR start happens with the track/holds frozen.
    a_r5_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |-> th_hold);

    // R6: the interrupt falls together with the track/hold release.
    a_r6_int_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $fell(th_hold));

    // R7: a start request during a running slot does not restart slot 0.
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && cnt != CNT_LAST && slot != '0) |=> slot != '0);
endmodule

// File: rtl/ssq_result_store.sv
// Four-entry result store with a sequential, wrapping read pointer.
// Contents are not reset; entries are valid only once written.
module ssq_result_store
    import ssq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_adv,
    input  logic              ptr_clr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NCH];
    logic [CH_W-1:0]   ptr;

    for (genvar i = 0; i < NCH; i++) begin : g_entry
        // Store the SAR result for this channel slot.
        always_ff @(posedge clk) begin
            if (we && waddr == CH_W'(i))
                mem[i] <= wdata;
        end
    end

    // Advance on each completed read; a conversion start rewinds to channel 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_clr)
            ptr <= '0;
        else if (rd_adv)
            ptr <= ptr + 1'b1;
    end

    assign rdata = mem[ptr];

    // R9: the pointer only moves on a completed read or a start edge.
    a_r9_ptr_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_adv && !ptr_clr) |=> $stable(ptr));
endmodule

// File: rtl/ssq_top.sv
// Top of the sampling sequencer: synchronizes host strobes, decodes their
// edges and ties together mode register, sequencer and result store.
// Assumes strobes are asynchronous and wider than three system clocks.
module ssq_top
    import ssq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int CONV_CLKS  = 32,
    parameter int PWRUP_CLKS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              conv_start,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [DATA_W-1:0] data_out,
    output logic              bus_oe,
    output logic              int_n,
    output logic              th_hold,
    output logic              pwr_dn,
    output logic              sar_start,
    output logic [CH_W-1:0]   sar_chan,
    output logic              sar_bank,
    input  logic              sar_done,
    input  logic [DATA_W-1:0] sar_data
);
    localparam int CS_B = 0, WR_B = 1, RD_B = 2, CV_B = 3;

    logic [3:0]        sl, sp;
    mode_t             mode;
    logic              ready, conv_rise, rd_rise, rd_fall;
    logic              mem_we;
    logic [CH_W-1:0]   mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    ssq_sync #(.W(4)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({conv_start, rd_n, wr_n, cs_n}),
        .lvl  (sl),
        .prev (sp)
    );

    assign conv_rise = sl[CV_B] && !sp[CV_B];
    assign rd_rise   = sl[RD_B] && !sp[RD_B] && !sp[CS_B];
    assign rd_fall   = !sl[RD_B] && sp[RD_B] && !sl[CS_B];

    ssq_mode_reg #(.PWRUP_CLKS(PWRUP_CLKS)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_lvl (sl[CS_B]),
        .cs_prev(sp[CS_B]),
        .wr_lvl (sl[WR_B]),
        .wr_prev(sp[WR_B]),
        .bus_nib(ctrl_in),
        .mode   (mode),
        .ready  (ready)
    );

    ssq_sequencer #(.CONV_CLKS(CONV_CLKS), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(conv_rise),
        .ready    (ready),
        .cnt_m1   (mode.cnt_m1),
        .bank     (mode.bank),
        .int_clr  (rd_fall),
        .sar_done (sar_done),
        .sar_data (sar_data),
        .sar_start(sar_start),
        .sar_chan (sar_chan),
        .sar_bank (sar_bank),
        .th_hold  (th_hold),
        .int_n    (int_n),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    ssq_result_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .waddr  (mem_addr),
        .wdata  (mem_wdata),
        .rd_adv (rd_rise),
        .ptr_clr(conv_rise),
        .rdata  (data_out)
    );

    assign bus_oe = !cs_n && !rd_n;
    assign pwr_dn = mode.pd;

    // R10: no conversion is started while powered down.
    a_r10_no_start_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> !sar_start);
endmodule

// File: tb/ssq_top_test.sv
module ssq_top_test;
    localparam int DW = 12;
    localparam int CC = 16;
    localparam int PU = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, conv_start = 1'b1;
    logic [3:0] ctrl_in = '0;
    logic [DW-1:0] data_out, sar_data;
    logic bus_oe, int_n, th_hold, pwr_dn, sar_start, sar_bank, sar_done;
    logic [1:0] sar_chan;

    int checks = 0, errors = 0;

    ssq_top #(.DATA_W(DW), .CONV_CLKS(CC), .PWRUP_CLKS(PU)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .conv_start(conv_start), .ctrl_in(ctrl_in), .data_out(data_out),
        .bus_oe(bus_oe), .int_n(int_n), .th_hold(th_hold), .pwr_dn(pwr_dn),
        .sar_start(sar_start), .sar_chan(sar_chan), .sar_bank(sar_bank),
        .sar_done(sar_done), .sar_data(sar_data)
    );

    always #10 clk = ~clk;

    // SAR core model: answers each start with a done pulse halfway through.
    logic [DW-1:0] sv_val [4];
    logic [DW-1:0] exp_mem [4];
    logic [1:0] chan_log [8];
    logic       bank_log [8];
    int         start_cnt = 0;
    int         cd = 0;
    logic [1:0] cur_ch = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sar_done <= 1'b0;
            sar_data <= '0;
            cd = 0;
        end else begin
            sar_done <= 1'b0;
            if (sar_start) begin
                if (start_cnt < 8) begin
                    chan_log[start_cnt] = sar_chan;
                    bank_log[start_cnt] = sar_bank;
                end
                start_cnt = start_cnt + 1;
                cur_ch = sar_chan;
                cd = CC / 2;
            end else if (cd != 0) begin
                cd = cd - 1;
                if (cd == 0) begin
                    sar_done <= 1'b1;
                    sar_data <= sv_val[cur_ch];
                end
            end
        end
    end

    function automatic int exp_count(input logic [3:0] w);
        return int'(w[1:0]) + 1;
    endfunction

    function automatic logic exp_bank(input logic [3:0] w);
        return w[2];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [3:0] w);
        cs_n = 1'b0; ctrl_in = w; wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(2);
        cs_n = 1'b1;
        cyc(4);
    endtask

    task automatic write_nocs(input logic [3:0] w);
        ctrl_in = w; wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(4);
    endtask

    task automatic write_cs_first(input logic [3:0] w, input logic [3:0] junk);
        cs_n = 1'b0; ctrl_in = w; wr_n = 1'b0;
        cyc(3);
        cs_n = 1'b1;
        cyc(3);
        ctrl_in = junk;
        cyc(2);
        wr_n = 1'b1;
        cyc(4);
    endtask

    task automatic read_one(output logic [DW-1:0] d, output logic oe);
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(3);
        d = data_out; oe = bus_oe;
        rd_n = 1'b1;
        cyc(4);
        cs_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_conv();
        conv_start = 1'b0;
        cyc(3);
        conv_start = 1'b1;
    endtask

    task automatic run_conv(input int n, input logic bank, input bit extra);
        int t, hi;
        for (int k = 0; k < 4; k++) sv_val[k] = DW'($urandom);
        start_cnt = 0;
        pulse_conv();
        t = 0;
        while (!th_hold && t < 20) begin cyc(1); t++; end
        hi = 0;
        while (th_hold && hi < 1000) begin
            hi++;
            if (extra && hi == 5) conv_start = 1'b0;
            if (extra && hi == 9) conv_start = 1'b1;
            cyc(1);
        end
        check("R6 hold length", hi, n * CC);
        check("R6 int low at end", int_n, 1'b0);
        check(extra ? "R7 start count" : "R5 start count", start_cnt, n);
        for (int k = 0; k < n && k < 8; k++) begin
            check("R5 channel order", chan_log[k], k);
            check("R2 bank", bank_log[k], bank);
            exp_mem[k] = sv_val[k];
        end
        cyc(3);
    endtask

    task automatic run_ignored(input string req);
        int hi = 0;
        start_cnt = 0;
        pulse_conv();
        for (int k = 0; k < 3 * CC; k++) begin
            if (th_hold) hi++;
            cyc(1);
        end
        check(req, hi, 0);
        check(req, start_cnt, 0);
    endtask

    task automatic read_check(input int ch, input string req);
        logic [DW-1:0] d;
        logic oe;
        read_one(d, oe);
        check("R8 oe during read", oe, 1'b1);
        check(req, d, exp_mem[ch]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic oe;
        logic [3:0] w;
        void'($urandom(32'd4242));
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        check("R1 int_n", int_n, 1'b1);
        check("R1 bus_oe", bus_oe, 1'b0);
        check("R1 th_hold", th_hold, 1'b0);
        check("R1 pwr_dn", pwr_dn, 1'b0);
        check("R1 sar_start", sar_start, 1'b0);

        // R1 default mode: bank A, one channel.
        run_conv(1, 1'b0, 1'b0);
        read_check(0, "R8 first read data");
        check("R8 int cleared by read", int_n, 1'b1);

        // R2 four channels on bank A, with R7 mid-sequence start edge.
        write_word(4'b0011);
        run_conv(4, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) read_check(k, "R8 sequential data");
        read_check(0, "R9 wrap after four");
        read_check(1, "R9 after wrap");
        // Pointer now at 2: a new start must rewind it.
        run_conv(4, 1'b0, 1'b0);
        read_check(0, "R9 rewind on start");

        // R4 writes and reads with CS high are ignored.
        write_nocs(4'b0101);
        cs_n = 1'b1; rd_n = 1'b0;
        cyc(3);
        check("R4 no drive cs high", bus_oe, 1'b0);
        rd_n = 1'b1;
        cyc(4);
        read_check(1, "R4 pointer unmoved");
        run_conv(4, 1'b0, 1'b0);

        // R3 CS rises first: word latched then, later bus junk ignored.
        write_cs_first(4'b0101, 4'b0010);
        run_conv(2, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) read_check(k, "R9 wrap ignores count");
        read_check(0, "R9 wrap ignores count");

        // Random modes.
        for (int i = 0; i < 6; i++) begin
            w = 4'($urandom % 8);
            write_word(w);
            run_conv(exp_count(w), exp_bank(w), bit'($urandom % 2));
            for (int k = 0; k < exp_count(w); k++) read_check(k, "R2 random mode data");
        end

        // R10 power-down, wake, settling.
        write_word(4'b1011);
        check("R10 pwr_dn set", pwr_dn, 1'b1);
        run_ignored("R10 ignored when down");
        write_word(4'b0110);
        check("R10 pwr_dn clear", pwr_dn, 1'b0);
        run_ignored("R10 ignored while settling");
        cyc(PU + 20);
        run_conv(3, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) read_check(k, "R10 wake mode data");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule